// File: doc/BRIEF.md
# Banked Queue Interrupt Controller

This block watches one status flag per queue and turns flag activity into interrupts for software. The queues are grouped into banks of equal width. Each bank owns a sticky status register, an enable register and one interrupt output. The output stays high while any status bit in its bank is set and also enabled. Software reaches the four registers over a single-cycle register bus with address, write enable, write data and combinational read data. A status bit is cleared by writing 1 to it.

A capture-mode input selects how flags are turned into status. In edge mode a status bit is set once per rising edge of its flag. A queue whose flag stays high cannot raise its bit again after software clears it. In level mode a status bit is set on every cycle its flag is high. Status is captured whether or not the queue is enabled, so software can enable a queue later and find pending events.

Top module: `qirq_ctrl`

## Requirements
- R1: After reset every status and enable bit is 0, both interrupt outputs are low, and every register reads 0.
- R2: Queue 32n+k maps to bit k of bank n. Bank n's status register sits at byte address 0x438+4n and its enable register at 0x430+4n, with n = 0 or 1. A read returns the addressed register in the same cycle.
- R3: An enable register reads back the last value written to it. Interrupt output n is high exactly when bank n has a bit that is set in both status and enable, and bank n's state never affects the other output.
- R4: In a status write, a 1 clears the bit and a 0 leaves it unchanged. A write never sets a status bit.
- R5: With cap_level = 0 (edge mode), a flag that is low at one clock edge and high at the next sets its status bit, visible right after that second edge. A flag held high does not set the bit again after a clear until it goes low and then high again.
- R6: With cap_level = 1 (level mode), a status bit is set at every edge at which its flag is high, so a clear only takes effect once the flag is low.
- R7: Status bits are captured even when the queue's enable bit is 0. Such a bit raises no interrupt until it is enabled.
- R8: When a capture and a write-1 clear hit the same bit at the same edge, the bit ends up set.
- R9: A read of any other address returns 0, and a write to any other address changes no register.
- R10: An interrupt output falls at the edge that clears the last bit of its bank that is set in both status and enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_flag | input | 64 | Per-queue status flags, bit i for queue i |
| cap_level | input | 1 | 0 selects edge capture, 1 selects level capture |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 2 | Interrupt line per bank, bit n for bank n |

## Verification
Flags, the capture mode and bus writes are all sampled at the same rising edge. Their effect on status, enable and irq is visible one cycle later, just after that edge. Read data is combinational on bus_addr and needs no wait. The bench updates its reference model with the inputs it holds across each edge. It then compares irq and the read data 1 ns after the edge, and it changes bus_addr for a read only inside that window, well clear of the next edge.

// File: rtl/qirq_pkg.sv
package qirq_pkg;

   typedef enum logic {
      CAP_EDGE  = 1'b0,
      CAP_LEVEL = 1'b1
   } cap_mode_e;

   // Byte address of register n in a pair of 4-byte-spaced registers.
   function automatic int unsigned reg_addr(int unsigned base, int unsigned idx);
      return base + 4 * idx;
   endfunction

endpackage

// File: rtl/qirq_capture.sv
module qirq_capture
   import qirq_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] flag,
   input  cap_mode_e    mode,
   output logic [W-1:0] evt
);

   logic [W-1:0] flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= flag;
   end

   always_comb begin
      if (mode == CAP_LEVEL) evt = flag;
      else                   evt = flag & ~flag_q;
   end

endmodule

// File: rtl/qirq_bank.sv
module qirq_bank #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic         en_we,
   input  logic         st_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] en,
   output logic [W-1:0] st,
   output logic         irq
);

   logic [W-1:0] st_nxt;

   always_comb begin
      st_nxt = st;
      if (st_we) st_nxt = st_nxt & ~wdata;
      st_nxt = st_nxt | evt;           // capture wins over clear (R8)
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= '0;
         en <= '0;
      end else begin
         st <= st_nxt;
         if (en_we) en <= wdata;
      end
   end

   assign irq = |(st & en);

   // R4: a written 1 leaves the bit clear unless a capture hit it.
   p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      st_we |=> ((st & $past(wdata) & ~$past(evt)) == '0));

   // R4: no status bit rises except through a capture.
   p_no_write_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((st & ~$past(st) & ~$past(evt)) == '0));

   // R8: a captured bit is always set after the edge.
   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((st & $past(evt)) == $past(evt)));

endmodule

// File: rtl/qirq_regmap.sv
module qirq_regmap #(
   parameter int          NB      = 2,
   parameter int          W       = 32,
   parameter int          ADDR_W  = 12,
   parameter int unsigned EN_BASE = 32'h430,
   parameter int unsigned ST_BASE = 32'h438
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [NB*W-1:0]   en_all,
   input  logic [NB*W-1:0]   st_all,
   output logic [NB-1:0]     en_we,
   output logic [NB-1:0]     st_we,
   output logic [W-1:0]      rdata
);
   import qirq_pkg::*;

   logic [NB-1:0] en_hit, st_hit;

   for (genvar n = 0; n < NB; n++) begin : g_dec
      localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(reg_addr(EN_BASE, n));
      localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(reg_addr(ST_BASE, n));
      assign en_hit[n] = (addr == EN_A);
      assign st_hit[n] = (addr == ST_A);
      assign en_we[n]  = we & en_hit[n];
      assign st_we[n]  = we & st_hit[n];
   end

   always_comb begin
      rdata = '0;
      for (int n = 0; n < NB; n++) begin
         if (en_hit[n]) rdata = en_all[n*W +: W];
         if (st_hit[n]) rdata = st_all[n*W +: W];
      end
   end

   // R9: an address outside the map reads 0.
   always_comb begin
      if (!(|{en_hit, st_hit}))
         a_unmapped_zero_r9: assert (rdata == '0);
   end

endmodule

// File: rtl/qirq_ctrl.sv
module qirq_ctrl
   import qirq_pkg::*;
#(
   parameter int          NUM_BANKS = 2,
   parameter int          BANK_W    = 32,
   parameter int          ADDR_W    = 12,
   parameter int unsigned EN_BASE   = 32'h430,
   parameter int unsigned ST_BASE   = 32'h438
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_BANKS*BANK_W-1:0] q_flag,
   input  logic                        cap_level,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic                        bus_we,
   input  logic [BANK_W-1:0]           bus_wdata,
   output logic [BANK_W-1:0]           bus_rdata,
   output logic [NUM_BANKS-1:0]        irq
);

   localparam int NQ      = NUM_BANKS * BANK_W;
   localparam int MAP_LEN = 4 * NUM_BANKS;

   // Elaboration-time parameter checks.
   if (NUM_BANKS < 1) begin : g_chk_nb
      $error("NUM_BANKS must be at least 1");
   end
   if (BANK_W < 1) begin : g_chk_w
      $error("BANK_W must be at least 1");
   end
   if ((EN_BASE % 4) != 0 || (ST_BASE % 4) != 0) begin : g_chk_align
      $error("register bases must be 4-byte aligned");
   end
   if (!((ST_BASE >= EN_BASE + MAP_LEN) || (EN_BASE >= ST_BASE + MAP_LEN))) begin : g_chk_ovl
      $error("enable and status ranges overlap");
   end
   if ((EN_BASE + MAP_LEN > (1 << ADDR_W)) || (ST_BASE + MAP_LEN > (1 << ADDR_W))) begin : g_chk_aw
      $error("register map exceeds ADDR_W");
   end

   cap_mode_e         mode;
   logic [NQ-1:0]     evt_all, en_all, st_all;
   logic [NUM_BANKS-1:0] en_we, st_we;

   assign mode = cap_mode_e'(cap_level);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      qirq_capture #(.W(BANK_W)) u_cap (
         .clk  (clk),
         .rst_n(rst_n),
         .flag (q_flag[b*BANK_W +: BANK_W]),
         .mode (mode),
         .evt  (evt_all[b*BANK_W +: BANK_W])
      );

      qirq_bank #(.W(BANK_W)) u_bank (
         .clk  (clk),
         .rst_n(rst_n),
         .evt  (evt_all[b*BANK_W +: BANK_W]),
         .en_we(en_we[b]),
         .st_we(st_we[b]),
         .wdata(bus_wdata),
         .en   (en_all[b*BANK_W +: BANK_W]),
         .st   (st_all[b*BANK_W +: BANK_W]),
         .irq  (irq[b])
      );
   end

   qirq_regmap #(
      .NB     (NUM_BANKS),
      .W      (BANK_W),
      .ADDR_W (ADDR_W),
      .EN_BASE(EN_BASE),
      .ST_BASE(ST_BASE)
   ) u_map (
      .addr  (bus_addr),
      .we    (bus_we),
      .en_all(en_all),
      .st_all(st_all),
      .en_we (en_we),
      .st_we (st_we),
      .rdata (bus_rdata)
   );

   // Goes high after the first edge out of reset, so that $past of the flags
   // matches what the capture stage has stored.
   logic chk_armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chk_armed <= 1'b0;
      else        chk_armed <= 1'b1;
   end

   // R5: in edge mode, unchanged flags set no new status bit.
   p_edge_no_refire_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_armed && !cap_level && q_flag == $past(q_flag))
         |=> ((st_all & ~$past(st_all)) == '0));

   // R10: with no status bit set, no interrupt line is raised.
   p_quiet_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_all == '0) |-> (irq == '0));

   // R1: registers come out of reset cleared.
   p_reset_clear_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (en_all == '0 && irq == '0));

endmodule

// File: tb/qirq_ctrl_test.sv
`timescale 1ns/1ps
module qirq_ctrl_test;

   localparam int NB = 2;
   localparam int W  = 32;
   localparam logic [11:0] EN0 = 12'h430, EN1 = 12'h434, ST0 = 12'h438, ST1 = 12'h43C, BAD = 12'h440;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [63:0]   q_flag = '0;
   logic          cap_level = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [1:0]    irq;

   qirq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .q_flag(q_flag), .cap_level(cap_level),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   always #10 clk = ~clk;   // 50 MHz

   int checks = 0;
   int errors = 0;
   logic [31:0] m_en [NB];
   logic [31:0] m_st [NB];
   logic [31:0] m_prev [NB];

   function automatic logic [31:0] exp_read(logic [11:0] a);
      if (a == EN0) return m_en[0];
      if (a == EN1) return m_en[1];
      if (a == ST0) return m_st[0];
      if (a == ST1) return m_st[1];
      return 32'h0;
   endfunction

   function automatic logic [1:0] exp_irq();
      return {|(m_st[1] & m_en[1]), |(m_st[0] & m_en[0])};
   endfunction

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   // Reference update for the inputs held across the next edge, then the edge.
   task automatic tick();
      for (int b = 0; b < NB; b++) begin
         logic [31:0] fl, ev;
         fl = q_flag[b*W +: W];
         ev = cap_level ? fl : (fl & ~m_prev[b]);
         if (bus_we && bus_addr == 12'(EN0 + 4*b)) m_en[b] = bus_wdata;
         if (bus_we && bus_addr == 12'(ST0 + 4*b)) m_st[b] = (m_st[b] & ~bus_wdata) | ev;
         else                                      m_st[b] = m_st[b] | ev;
         m_prev[b] = fl;
      end
      @(posedge clk);
      #1;
      bus_we = 1'b0;
   endtask

   task automatic write(logic [11:0] a, logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      tick();
   endtask

   task automatic read_chk(string req, logic [11:0] a);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp_read(a));
   endtask

   task automatic all_chk(string req);
      read_chk(req, EN0); read_chk(req, EN1);
      read_chk(req, ST0); read_chk(req, ST1);
      check(req, {30'b0, irq}, {30'b0, exp_irq()});
   endtask

   logic done = 1'b0;
   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int b = 0; b < NB; b++) begin m_en[b] = '0; m_st[b] = '0; m_prev[b] = '0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state
      all_chk("R1 reset");
      check("R1 irq low", {30'b0, irq}, 32'h0);

      // R2 / R7: queue 37 -> bank 1 bit 5, captured while disabled
      q_flag[37] = 1'b1;
      tick();
      read_chk("R2 bank1 status", ST1);
      check("R2 bit 5 literal", bus_rdata, 32'h20);
      read_chk("R2 bank0 untouched", ST0);
      check("R7 no irq while disabled", {30'b0, irq}, 32'h0);

      // R3: enable bank 1 bit 5
      write(EN1, 32'h0000_0020);
      read_chk("R3 enable readback", EN1);
      check("R3 irq per bank", {30'b0, irq}, 32'h2);

      // R4: write of 0 leaves status
      write(ST1, 32'h0);
      read_chk("R4 zero write keeps", ST1);

      // R5 / R10: clear while flag held high does not refire
      write(ST1, 32'h20);
      read_chk("R5 cleared", ST1);
      check("R10 irq drops", {30'b0, irq}, 32'h0);
      tick();
      read_chk("R5 no refire held", ST1);
      q_flag[37] = 1'b0; tick();
      read_chk("R5 flag low", ST1);
      q_flag[37] = 1'b1; tick();
      read_chk("R5 refire after new edge", ST1);
      check("R5 literal", bus_rdata, 32'h20);

      // R8: capture and clear at the same edge
      q_flag[3] = 1'b1;
      write(ST0, 32'h8);
      read_chk("R8 set wins", ST0);
      check("R8 literal", bus_rdata & 32'h8, 32'h8);

      // R6: level mode re-sets while high
      cap_level = 1'b1;
      write(ST0, 32'h8);
      read_chk("R6 level keeps set", ST0);
      q_flag[3] = 1'b0;
      write(ST0, 32'h8);
      read_chk("R6 clear sticks when low", ST0);
      check("R6 literal", bus_rdata & 32'h8, 32'h0);
      cap_level = 1'b0;

      // R9: unmapped address
      read_chk("R9 unmapped read", BAD);
      check("R9 literal", bus_rdata, 32'h0);
      write(BAD, 32'hFFFF_FFFF);
      all_chk("R9 unmapped write");

      // Random phase: R2 R3 R4 R5 R6 R7
      for (int i = 0; i < 600; i++) begin
         logic [11:0] addrs [5];
         addrs = '{EN0, EN1, ST0, ST1, BAD};
         q_flag = q_flag ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
         if ($urandom_range(0, 49) == 0) cap_level = ~cap_level;
         if ($urandom_range(0, 9) < 3) begin
            bus_addr  = addrs[$urandom_range(0, 4)];
            bus_wdata = $urandom;
            bus_we    = 1'b1;
         end
         tick();
         check("R3 irq random", {30'b0, irq}, {30'b0, exp_irq()});
         read_chk("R2 random read", addrs[$urandom_range(0, 4)]);
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule